// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block turns one 16-bit instruction word into the control fields that the execute stage of a small 16-bit processor needs. The fields are the opcode, the encoding format, a destination register index, a second operand, a condition code, a flag-update enable and an illegal-instruction flag. The second operand is either a register index or an immediate widened to the datapath width. The top five bits of the word select the opcode. The opcode fixes which of three layouts the remaining eleven bits follow:

- A register/operand layout with a two-bit condition field.
- A move-immediate layout with no condition field.
- A branch/trap layout whose condition field is three bits wide.

Legality is checked in the same cycle as the field extraction. The verdict is registered alongside the decoded fields. A downstream stage treats a set illegal flag as a trap request rather than an instruction to execute. The output stage loads only on cycles where the input is marked valid. The output valid strobe follows the input strobe with one cycle of latency. Reset is asserted asynchronously and released through a short synchronizer.

Top module: `idec_top`

## Requirements
- R1: After reset `out_valid` is 0 and stays 0 until a cycle with `in_valid` high. Each `out_valid` equals the `in_valid` of the previous clock edge.
- R2: Opcode 31 (word bits 15:11 all ones) sets `out_illegal`. For this opcode, format code 3 is reported and every other field reads 0.
- R3: Register/operand format (every opcode except 3, 9, 11, 17, 19, 20 and 31) maps fields as follows:
  - `out_dst` = bits 10:8.
  - `out_cond` = bits 7:6 with a 0 above them, so the code is never above 3.
  - `out_flag_upd` = bit 4.
- R4: In register/operand format, bit 5 selects the operand:
  - Bit 5 = 1: `out_op_is_imm`=1, `out_op_imm` is bits 3:0 sign-extended from bit 3, and `out_op_reg`=0.
  - Bit 5 = 0: `out_op_is_imm`=0, `out_op_reg` = bits 2:0, and `out_op_imm`=0.
- R5: Move-low (9) and move-high (11) produce the following fields:
  - `out_dst` = bits 10:8.
  - `out_cond`=0 and `out_flag_upd`=0.
  - `out_op_is_imm`=1, with `out_op_imm` = bits 7:0 zero-extended.
  - Bit 4 is immediate data here and never makes the word illegal.
- R6: Branch (3), return (17), system call (19) and segment select (20) produce the following fields:
  - `out_cond` = bits 10:8, `out_dst`=0 and `out_flag_upd`=0.
  - Branch sign-extends bits 7:0.
  - System call and segment select zero-extend bits 7:0.
  - Return carries no operand (`out_op_is_imm`=0, `out_op_imm`=0).
- R7: Signed compare (4) and unsigned compare (27) always report `out_flag_upd`=1, whatever bit 4 holds.
- R8: Subroutine jump (5), push (16), byte store (23) and word store (24) with bit 4 set are illegal. With bit 4 clear they are legal, as is every other opcode below 31.
- R9: On a cycle with `in_valid` low, all decoded outputs keep their previous values.
- R10: `out_fmt` reports the format as 0 = register/operand, 1 = move-immediate, 2 = branch/trap and 3 = reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields are new this cycle |
| out_opcode | output | 5 | Opcode (bits 15:11) |
| out_fmt | output | 2 | Encoding format code |
| out_dst | output | 3 | Destination register index |
| out_cond | output | 3 | Condition code |
| out_flag_upd | output | 1 | Flags are to be updated |
| out_op_is_imm | output | 1 | Second operand is an immediate |
| out_op_reg | output | 3 | Second operand register index |
| out_op_imm | output | DATA_W | Extended immediate |
| out_illegal | output | 1 | Trap request: reserved or disallowed encoding |

## Verification
The hardest cases to reach are where bit 4 means different things depending on the opcode. It is a forbidden flag request for the store, push and jump opcodes. It is plain immediate data in the move and branch/trap layouts, and it is overridden for the two compares. Only a few specific words fall on those boundaries. The bench therefore drives all 65,536 instruction words back to back with the input strobe held high, so every opcode meets every value of bit 4, bit 5 and the sign bits. Each result is compared against fields computed arithmetically from the bit positions. A final phase drops the strobe while changing the word, which shows that the held fields and the valid strobe behave as required.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int WORD_W = 16;
  localparam int OPC_W  = 5;
  localparam int REG_W  = 3;
  localparam int COND_W = 3;

  // Opcode values the decoder treats specially
  localparam logic [OPC_W-1:0] OPC_BRANCH  = 5'd3;
  localparam logic [OPC_W-1:0] OPC_CMP_S   = 5'd4;
  localparam logic [OPC_W-1:0] OPC_CALL    = 5'd5;
  localparam logic [OPC_W-1:0] OPC_MOVLO   = 5'd9;
  localparam logic [OPC_W-1:0] OPC_MOVHI   = 5'd11;
  localparam logic [OPC_W-1:0] OPC_PUSH    = 5'd16;
  localparam logic [OPC_W-1:0] OPC_RETURN  = 5'd17;
  localparam logic [OPC_W-1:0] OPC_SYSCALL = 5'd19;
  localparam logic [OPC_W-1:0] OPC_SEGSEL  = 5'd20;
  localparam logic [OPC_W-1:0] OPC_STBYTE  = 5'd23;
  localparam logic [OPC_W-1:0] OPC_STWORD  = 5'd24;
  localparam logic [OPC_W-1:0] OPC_CMP_U   = 5'd27;
  localparam logic [OPC_W-1:0] OPC_RSV     = 5'd31;

  typedef enum logic [1:0] {
    FMT_REG = 2'd0,
    FMT_MOV = 2'd1,
    FMT_JMP = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  // Per-opcode properties, produced by the classifier
  typedef struct packed {
    fmt_e fmt;
    logic force_flag;   // compare: flags always written
    logic bars_flag;    // flag request is illegal
    logic imm_signed;   // 8-bit immediate is sign-extended
    logic has_operand;  // branch/trap form carries an immediate
  } opc_info_t;

  // Decoded fields except the width-parameterised immediate
  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    fmt_e              fmt;
    logic [REG_W-1:0]  dst;
    logic [COND_W-1:0] cond;
    logic              flag_upd;
    logic              op_is_imm;
    logic [REG_W-1:0]  op_reg;
    logic              illegal;
  } dec_t;

endpackage

// File: rtl/idec_rst_sync.sv
module idec_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output opc_info_t        info
);

  always_comb begin
    info             = '0;
    info.fmt         = FMT_REG;
    unique case (opcode)
      OPC_MOVLO, OPC_MOVHI: begin
        info.fmt = FMT_MOV;
      end
      OPC_BRANCH: begin
        info.fmt         = FMT_JMP;
        info.imm_signed  = 1'b1;
        info.has_operand = 1'b1;
      end
      OPC_SYSCALL, OPC_SEGSEL: begin
        info.fmt         = FMT_JMP;
        info.has_operand = 1'b1;
      end
      OPC_RETURN: begin
        info.fmt = FMT_JMP;
      end
      OPC_CMP_S, OPC_CMP_U: begin
        info.force_flag = 1'b1;
      end
      OPC_CALL, OPC_PUSH, OPC_STBYTE, OPC_STWORD: begin
        info.bars_flag = 1'b1;
      end
      OPC_RSV: begin
        info.fmt = FMT_RSV;
      end
      default: begin
        info.fmt = FMT_REG;
      end
    endcase
  end

endmodule

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [WORD_W-1:0] word,
  input  opc_info_t         info,
  output dec_t              dec,
  output logic [DATA_W-1:0] imm
);

  localparam int SHORT_W = 4;
  localparam int LONG_W  = 8;

  logic [DATA_W-1:0] short_sext;
  logic [DATA_W-1:0] long_sext;
  logic [DATA_W-1:0] long_zext;

  assign short_sext = {{(DATA_W-SHORT_W){word[SHORT_W-1]}}, word[SHORT_W-1:0]};
  assign long_sext  = {{(DATA_W-LONG_W){word[LONG_W-1]}}, word[LONG_W-1:0]};
  assign long_zext  = {{(DATA_W-LONG_W){1'b0}}, word[LONG_W-1:0]};

  always_comb begin
    dec        = '0;
    imm        = '0;
    dec.opcode = word[15:11];
    dec.fmt    = info.fmt;
    unique case (info.fmt)
      FMT_REG: begin
        dec.dst       = word[10:8];
        dec.cond      = {1'b0, word[7:6]};
        dec.flag_upd  = word[4] | info.force_flag;
        dec.op_is_imm = word[5];
        dec.op_reg    = word[5] ? '0 : word[2:0];
        imm           = word[5] ? short_sext : '0;
        dec.illegal   = info.bars_flag & word[4];
      end
      FMT_MOV: begin
        dec.dst       = word[10:8];
        dec.op_is_imm = 1'b1;
        imm           = long_zext;
      end
      FMT_JMP: begin
        dec.cond      = word[10:8];
        dec.op_is_imm = info.has_operand;
        if (info.has_operand) imm = info.imm_signed ? long_sext : long_zext;
      end
      default: begin
        dec.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_word,
  output logic              out_valid,
  output logic [4:0]        out_opcode,
  output logic [1:0]        out_fmt,
  output logic [2:0]        out_dst,
  output logic [2:0]        out_cond,
  output logic              out_flag_upd,
  output logic              out_op_is_imm,
  output logic [2:0]        out_op_reg,
  output logic [DATA_W-1:0] out_op_imm,
  output logic              out_illegal
);

  logic              rst_sync_n;
  opc_info_t         info;
  dec_t              dec_comb;
  logic [DATA_W-1:0] imm_comb;

  dec_t              dec_q, dec_d;
  logic [DATA_W-1:0] imm_q, imm_d;
  logic              vld_q, vld_d;

  idec_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  idec_classify u_classify (
    .opcode (in_word[15:11]),
    .info   (info)
  );

  idec_fields #(.DATA_W(DATA_W)) u_fields (
    .word (in_word),
    .info (info),
    .dec  (dec_comb),
    .imm  (imm_comb)
  );

  // Next state: decoded fields load only with a valid input word
  always_comb begin
    vld_d = in_valid;
    dec_d = dec_q;
    imm_d = imm_q;
    if (in_valid) begin
      dec_d = dec_comb;
      imm_d = imm_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      dec_q <= '0;
      imm_q <= '0;
    end else begin
      vld_q <= vld_d;
      dec_q <= dec_d;
      imm_q <= imm_d;
    end
  end

  assign out_valid     = vld_q;
  assign out_opcode    = dec_q.opcode;
  assign out_fmt       = dec_q.fmt;
  assign out_dst       = dec_q.dst;
  assign out_cond      = dec_q.cond;
  assign out_flag_upd  = dec_q.flag_upd;
  assign out_op_is_imm = dec_q.op_is_imm;
  assign out_op_reg    = dec_q.op_reg;
  assign out_op_imm    = imm_q;
  assign out_illegal   = dec_q.illegal;

  p_valid_src_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(in_valid));

  p_rsv_trap_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_opcode == 5'd31) |-> (out_illegal && out_fmt == 2'd3));

  p_ccond_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_fmt == 2'd0) |-> !out_cond[2]);

  p_imm_excl_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_op_is_imm) |-> (out_op_reg == 3'd0));

  p_movi_cond_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_fmt == 2'd1) |-> (out_cond == 3'd0 && !out_flag_upd && !out_illegal));

  p_cmp_flag_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && (out_opcode == 5'd4 || out_opcode == 5'd27)) |-> out_flag_upd);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_opcode) && $stable(out_illegal) && $stable(out_op_imm)
                   && $stable(out_cond) && $stable(out_dst)));

endmodule

// File: tb/idec_top_bench.sv
module idec_top_bench;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [15:0]   in_word;
  logic          out_valid;
  logic [4:0]    out_opcode;
  logic [1:0]    out_fmt;
  logic [2:0]    out_dst;
  logic [2:0]    out_cond;
  logic          out_flag_upd;
  logic          out_op_is_imm;
  logic [2:0]    out_op_reg;
  logic [DW-1:0] out_op_imm;
  logic          out_illegal;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  idec_top #(.DATA_W(DW)) u_idec_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_fmt(out_fmt),
    .out_dst(out_dst), .out_cond(out_cond), .out_flag_upd(out_flag_upd),
    .out_op_is_imm(out_op_is_imm), .out_op_reg(out_op_reg),
    .out_op_imm(out_op_imm), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (word=%04h)", tag, what, act, exp, in_word);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // Expected fields computed from the bit positions in the requirements
  task automatic check_word(input logic [15:0] w);
    int opc, e_fmt, e_dst, e_cond, e_flag, e_isimm, e_reg, e_imm, e_ill;
    string t_fld, t_op, t_flag, t_ill;
    opc = int'(w[15:11]);
    e_dst = 0; e_cond = 0; e_flag = 0; e_isimm = 0; e_reg = 0; e_imm = 0; e_ill = 0;
    if (opc == 31) begin
      e_fmt = 3; e_ill = 1;
      t_fld = "R2"; t_op = "R2"; t_flag = "R2"; t_ill = "R2";
    end else if (opc == 9 || opc == 11) begin
      e_fmt = 1; e_dst = int'(w[10:8]); e_isimm = 1; e_imm = int'(w[7:0]);
      t_fld = "R5"; t_op = "R5"; t_flag = "R5"; t_ill = "R5";
    end else if (opc == 3 || opc == 17 || opc == 19 || opc == 20) begin
      e_fmt = 2; e_cond = int'(w[10:8]);
      if (opc != 17) begin
        e_isimm = 1;
        e_imm = int'(w[7:0]);
        if (opc == 3 && w[7]) e_imm = (e_imm - 256) & 16'hFFFF;
      end
      t_fld = "R6"; t_op = "R6"; t_flag = "R6"; t_ill = "R8";
    end else begin
      e_fmt = 0; e_dst = int'(w[10:8]); e_cond = int'(w[7:6]);
      e_flag = (w[4] || opc == 4 || opc == 27) ? 1 : 0;
      e_isimm = int'(w[5]);
      if (w[5]) begin
        e_imm = int'(w[3:0]);
        if (w[3]) e_imm = (e_imm - 16) & 16'hFFFF;
      end else begin
        e_reg = int'(w[2:0]);
      end
      e_ill = (w[4] && (opc == 5 || opc == 16 || opc == 23 || opc == 24)) ? 1 : 0;
      t_fld = "R3"; t_op = "R4";
      t_flag = (opc == 4 || opc == 27) ? "R7" : "R3";
      t_ill = "R8";
    end
    chk("R1", "valid", int'(out_valid), 1);
    chk("R10", "fmt", int'(out_fmt), e_fmt);
    chk(t_fld, "opcode", int'(out_opcode), opc);
    chk(t_fld, "dst", int'(out_dst), e_dst);
    chk(t_fld, "cond", int'(out_cond), e_cond);
    chk(t_flag, "flag_upd", int'(out_flag_upd), e_flag);
    chk(t_op, "op_is_imm", int'(out_op_is_imm), e_isimm);
    chk(t_op, "op_reg", int'(out_op_reg), e_reg);
    chk(t_op, "op_imm", int'(out_op_imm), e_imm);
    chk(t_ill, "illegal", int'(out_illegal), e_ill);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_word = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    // Synchronizer stages pass; no valid word yet
    repeat (4) @(negedge clk);
    chk("R1", "valid before first word", int'(out_valid), 0);
    chk("R1", "illegal before first word", int'(out_illegal), 0);

    // Exhaustive sweep: every word, one per cycle
    for (int w = 0; w < 65536; w++) begin
      in_word  = w[15:0];
      in_valid = 1'b1;
      @(negedge clk);
      check_word(w[15:0]);
    end

    // R9: last latched word was 16'hFFFF (reserved); drop valid, change word
    in_valid = 1'b0;
    in_word  = 16'h0000;
    @(negedge clk);
    chk("R1", "valid after idle", int'(out_valid), 0);
    chk("R9", "held opcode", int'(out_opcode), 31);
    chk("R9", "held illegal", int'(out_illegal), 1);
    chk("R9", "held fmt", int'(out_fmt), 3);
    @(negedge clk);
    chk("R9", "held opcode second idle", int'(out_opcode), 31);

    // Resume with a legal word
    in_valid = 1'b1;
    in_word  = 16'h0000;
    @(negedge clk);
    check_word(16'h0000);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule